// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block watches a bank of interrupt input lines and turns each one into a single write message. Each line has a two-word routing entry. The low word holds the mask, trigger and polarity controls and the 8-bit payload. The high word holds the destination, which becomes the message address. The message leaves on a valid/ready request port. Only one message is in flight at a time, and lines with work waiting are served in round-robin order.

Software reaches the routing table through a simple 32-bit register bus. A select register chooses an internal index, and a data window reads or writes that index. Index 0x01 is a read-only identification word. A third register takes end-of-interrupt writes. These re-arm level-sensitive lines whose payload matches the written value. Edge-sensitive lines keep a pending flag. The flag is cleared when the message is taken, and these lines never need an end-of-interrupt write.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset, no message is offered, every low word reads 0x0001_0000 (masked, edge, active high, payload 0), and every high word reads zero.
- R2: Internal index 0x01 reads {8'h00, LINES-1, 8'h00, VERSION}, which is 0x000F_0021 with the default parameters, and writes to it change nothing.
- R3: Bus offset 0x00 is the select register and offset 0x10 is the window. Line n has its low word at index 0x10+2n and its high word at index 0x11+2n, and a window read returns the value last written there.
- R4: A window write to an index that is neither 0x01 nor inside the table is dropped, and a window read of such an index returns zero.
- R5: With low-word bit 15 clear (edge mode), each active edge yields exactly one message. The message carries msg_data = low[7:0] and msg_addr = {high[31:24], high[23:16]}.
- R6: Low-word bit 13 set makes the line active low, so the falling edge of the input is its active edge and the rising edge is not.
- R7: With low-word bit 15 set (level mode), an active line sends one message and then sends nothing more while it stays active, until an end-of-interrupt write.
- R8: A write to bus offset 0x40 re-arms every level-mode line whose payload equals wdata[7:0]. Such a line, if still active and unmasked, sends again. A write with a value that matches no payload re-arms nothing.
- R9: Low-word bit 16 set blocks the line's messages. An edge seen while masked stays pending and is sent once the mask is cleared.
- R10: msg_valid, msg_addr and msg_data stay unchanged until msg_ready is seen high, and msg_valid is low in the cycle after that acceptance.
- R11: When several lines are waiting, the next message goes to the first waiting line after the most recently served line, in increasing index order with wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, registered on the edge that samples bus_rd_en |
| irq_in | input | 16 | Interrupt input lines, synchronous to clk |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted when high with msg_valid |
| msg_addr | output | 16 | Destination {ID, extended ID} |
| msg_data | output | 8 | Message payload |

## Verification
- **Level-mode lines:** msg_valid rises one clock edge after the input turns active.
- **Edge-mode lines:** msg_valid rises two edges after the input edge, because the pending flag sits in between.
- **Register reads:** read data is registered on the edge that samples the read strobe.

The bench holds msg_ready low while it waits, so any message stays frozen on the port. It then samples on a falling edge four cycles after the stimulus, which is past the latest due cycle. After a one-cycle acceptance pulse, it checks that msg_valid is already low on the next falling edge. For the "nothing happens" cases, it waits the same four cycles and confirms that msg_valid stayed low.

// File: rtl/irr_pkg.sv
// Shared constants and the per-line routing view used across the
// redirection controller. Assumes an 8-bit byte offset on the register bus.
package irr_pkg;
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EOI    = 8'h40;

    localparam int IDX_IDENT      = 1;
    localparam int IDX_TABLE_BASE = 16;

    localparam int BIT_MASK    = 16;
    localparam int BIT_LEVEL   = 15;
    localparam int BIT_POL_LOW = 13;

    localparam logic [31:0] LOW_RESET = 32'h0001_0000;

    typedef struct packed {
        logic        mask;
        logic        level;
        logic        pol_low;
        logic [7:0]  data;
        logic [15:0] dest;
    } irr_route_t;
endpackage

// File: rtl/irr_regfile.sv
// Register front end: select/window access to the routing table and the
// identification word, plus the end-of-interrupt strobe.
// Assumes single-cycle write and read strobes; read data is registered.
module irr_regfile
    import irr_pkg::*;
#(
    parameter int         NUM_LINES = 16,
    parameter int         SEL_W     = 8,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr_en,
    input  logic                              bus_rd_en,
    input  logic [7:0]                        bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output irr_route_t [NUM_LINES-1:0]        route,
    output logic                              eoi_valid,
    output logic [7:0]                        eoi_val
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [SEL_W-1:0] BASE_IDX  = SEL_W'(IDX_TABLE_BASE);
    localparam logic [SEL_W-1:0] TOP_IDX   = SEL_W'(IDX_TABLE_BASE + 2*NUM_LINES - 1);
    localparam logic [SEL_W-1:0] IDENT_IDX = SEL_W'(IDX_IDENT);
    localparam logic [31:0] IDENT_WORD = {8'h00, 8'(NUM_LINES-1), 8'h00, VERSION};

    logic [SEL_W-1:0]             sel_q;
    logic [NUM_LINES-1:0][31:0]   lo_q;
    logic [NUM_LINES-1:0][31:0]   hi_q;
    logic                         wr_sel, wr_win, in_tab, is_hi;
    logic [SEL_W-1:0]             sel_off;
    logic [LINE_W-1:0]            ent_n;
    logic [31:0]                  win_val;

    // Decode the bus strobes and locate the selected table word.
    always_comb begin
        wr_sel  = bus_wr_en && (bus_addr == OFS_SELECT);
        wr_win  = bus_wr_en && (bus_addr == OFS_WINDOW);
        in_tab  = (sel_q >= BASE_IDX) && (sel_q <= TOP_IDX);
        sel_off = sel_q - BASE_IDX;
        ent_n   = sel_off[LINE_W:1];
        is_hi   = sel_off[0];
    end

    assign eoi_valid = bus_wr_en && (bus_addr == OFS_EOI);
    assign eoi_val   = bus_wdata[7:0];

    // Hold the select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
    end

    // Store routing words written through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                lo_q[i] <= LOW_RESET;
                hi_q[i] <= '0;
            end
        end else if (wr_win && in_tab) begin
            if (is_hi) hi_q[ent_n] <= bus_wdata;
            else       lo_q[ent_n] <= bus_wdata;
        end
    end

    // Select the value seen through the window.
    always_comb begin
        if (in_tab)                  win_val = is_hi ? hi_q[ent_n] : lo_q[ent_n];
        else if (sel_q == IDENT_IDX) win_val = IDENT_WORD;
        else                         win_val = '0;
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd_en) begin
            if (bus_addr == OFS_SELECT)      bus_rdata <= 32'(sel_q);
            else if (bus_addr == OFS_WINDOW) bus_rdata <= win_val;
            else                             bus_rdata <= '0;
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_route
        assign route[g].mask    = lo_q[g][BIT_MASK];
        assign route[g].level   = lo_q[g][BIT_LEVEL];
        assign route[g].pol_low = lo_q[g][BIT_POL_LOW];
        assign route[g].data    = lo_q[g][7:0];
        assign route[g].dest    = hi_q[g][31:16];
    end

    // R4: a window write outside the table leaves every routing word alone.
    a_r4_stray_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_win && !in_tab) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/irr_line.sv
// Per-line state: input edge history, edge pending flag, level in-service
// flag. Assumes irq is already synchronous to clk.
module irr_line
    import irr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq,
    input  irr_route_t route,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_val,
    input  logic       accept,
    output logic       req
);
    logic irq_q, pend_q, insvc_q;
    logic edge_evt, active, eoi_hit;

    // Detect the active edge on the raw input and the active level.
    always_comb begin
        edge_evt = route.pol_low ? (irq_q & ~irq) : (irq & ~irq_q);
        active   = irq ^ route.pol_low;
        eoi_hit  = eoi_valid && route.level && (eoi_val == route.data);
        req      = !route.mask && (route.level ? (active && !insvc_q) : pend_q);
    end

    // Track input history, edge pending and level in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            pend_q  <= 1'b0;
            insvc_q <= 1'b0;
        end else begin
            irq_q   <= irq;
            pend_q  <= (pend_q && !accept) || (edge_evt && !route.level);
            insvc_q <= (insvc_q && !eoi_hit) || (accept && route.level);
        end
    end

    // R7: a level line that was just served asks for nothing next cycle.
    a_r7_level_once: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && route.level) |=> (!req || !route.level));
endmodule

// File: rtl/irr_rr_arb.sv
// Round-robin picker: grants the first requester after the last served
// index. The pointer advances only when the caller takes the grant.
module irr_rr_arb #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             take,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;

    // Search upward from the entry after the last served one.
    always_comb begin
        int c;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last_q) + k) % N;
            if (!gnt_valid && req[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(c);
            end
        end
    end

    // Remember the most recently served index.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= IDX_W'(N-1);
        else if (take) last_q <= gnt_idx;
    end

    // R11: a grant always names a line that is asking.
    a_r11_grant_is_request: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/irq_redirect_ctrl.sv
// Top: line-to-message interrupt redirection. Holds one outstanding
// message on a valid/ready port, fed by a round-robin pick over lines.
module irq_redirect_ctrl
    import irr_pkg::*;
#(
    parameter int         NUM_LINES = 16,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [15:0]          msg_addr,
    output logic [7:0]           msg_data
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    irr_route_t [NUM_LINES-1:0] route;
    logic                       eoi_valid;
    logic [7:0]                 eoi_val;
    logic [NUM_LINES-1:0]       req, accept_vec, mask_vec, mask_prev;
    logic                       gnt_valid, take, done;
    logic [IDX_W-1:0]           gnt_idx, idx_q;

    irr_regfile #(.NUM_LINES(NUM_LINES), .SEL_W(8), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .route(route), .eoi_valid(eoi_valid), .eoi_val(eoi_val));

    assign done = msg_valid && msg_ready;
    assign take = gnt_valid && !msg_valid;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign accept_vec[g] = done && (idx_q == IDX_W'(g));
        assign mask_vec[g]   = route[g].mask;
        irr_line u_line (
            .clk(clk), .rst_n(rst_n), .irq(irq_in[g]), .route(route[g]),
            .eoi_valid(eoi_valid), .eoi_val(eoi_val),
            .accept(accept_vec[g]), .req(req[g]));
    end

    irr_rr_arb #(.N(NUM_LINES), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .take(take),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

    // Load, hold and retire the single outstanding message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            idx_q     <= '0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (done) begin
            msg_valid <= 1'b0;
        end else if (take) begin
            msg_valid <= 1'b1;
            idx_q     <= gnt_idx;
            msg_addr  <= route[gnt_idx].dest;
            msg_data  <= route[gnt_idx].data;
        end
    end

    // Keep the mask view of the previous cycle for the launch check.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_prev <= '1;
        else        mask_prev <= mask_vec;
    end

    // R10: an unaccepted message holds its contents.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    // R10: acceptance retires the message in the next cycle.
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);
    // R9: no message launches for a line that was masked at grant time.
    a_r9_no_masked_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !mask_prev[idx_q]);
endmodule

// File: tb/tb_irq_redirect_ctrl.sv
`timescale 1ns/1ps
module tb_irq_redirect_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [15:0] msg_addr;
    logic [7:0]  msg_data;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_redirect_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data));

    // {index, write value, expected read-back}
    localparam logic [71:0] VEC [8] = '{
        {8'h10, 32'h0001_A055, 32'h0001_A055},
        {8'h11, 32'h1234_5678, 32'h1234_5678},
        {8'h2F, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h2E, 32'h0001_0000, 32'h0001_0000},
        {8'h01, 32'hFFFF_FFFF, 32'h000F_0021},
        {8'h30, 32'h0000_0005, 32'h0000_0000},
        {8'h0F, 32'h0000_0001, 32'h0000_0000},
        {8'h00, 32'h1111_1111, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic put(input logic [7:0] idx, input logic [31:0] v);
        bus_wr(8'h00, 32'(idx));
        bus_wr(8'h10, v);
    endtask

    task automatic get(input logic [7:0] idx, output logic [31:0] v);
        bus_wr(8'h00, 32'(idx));
        bus_rd(8'h10, v);
    endtask

    // Expect a held message, then accept it and see valid drop.
    task automatic take_msg(input string tag, input logic [7:0] d, input logic [15:0] a, input bit chk_a);
        wait_cyc(4);
        chk({tag, " valid"}, 32'(msg_valid), 32'd1);
        chk({tag, " data"}, 32'(msg_data), 32'(d));
        if (chk_a) chk({tag, " addr"}, 32'(msg_addr), 32'(a));
        @(negedge clk) msg_ready = 1'b1;
        @(negedge clk) msg_ready = 1'b0;
        chk("R10 valid low after accept", 32'(msg_valid), 32'd0);
    endtask

    task automatic expect_quiet(input string tag);
        wait_cyc(4);
        chk(tag, 32'(msg_valid), 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 no message after reset", 32'(msg_valid), 32'd0);
        get(8'h16, rv); chk("R1 low word reset", rv, 32'h0001_0000);
        get(8'h17, rv); chk("R1 high word reset", rv, 32'h0);

        // Table walk: R2 ident, R3 table words, R4 stray indices
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ix;
            string tg;
            ix = VEC[i][71:64];
            tg = (ix == 8'h01) ? "R2 ident" :
                 ((ix >= 8'h10 && ix <= 8'h2F) ? "R3 readback" : "R4 stray index");
            put(ix, VEC[i][63:32]);
            bus_rd(8'h10, rv);
            chk(tg, rv, VEC[i][31:0]);
        end

        // R5 edge line 2 with destination, R10 hold
        put(8'h15, 32'hABCD_0000);
        put(8'h14, 32'h0000_0042);
        @(negedge clk) irq_in[2] = 1'b1;
        wait_cyc(7);
        chk("R10 held while not ready", 32'(msg_valid), 32'd1);
        take_msg("R5 edge line", 8'h42, 16'hABCD, 1);
        expect_quiet("R5 one message per edge");
        @(negedge clk) irq_in[2] = 1'b0;

        // R6 active-low edge line 4
        put(8'h18, 32'h0000_2077);
        @(negedge clk) irq_in[4] = 1'b1;
        expect_quiet("R6 rising edge ignored when active low");
        @(negedge clk) irq_in[4] = 1'b0;
        take_msg("R6 falling edge", 8'h77, 16'h0, 0);

        // R7 / R8 level line 6
        put(8'h1D, 32'h1256_0000);
        put(8'h1C, 32'h0000_8055);
        @(negedge clk) irq_in[6] = 1'b1;
        take_msg("R7 level first", 8'h55, 16'h1256, 1);
        expect_quiet("R7 blocked until EOI");
        bus_wr(8'h40, 32'h0000_0054);
        expect_quiet("R8 non-matching EOI");
        bus_wr(8'h40, 32'h0000_0055);
        take_msg("R8 EOI refires active line", 8'h55, 16'h1256, 1);
        @(negedge clk) irq_in[6] = 1'b0;
        bus_wr(8'h40, 32'h0000_0055);
        expect_quiet("R8 EOI with line inactive");

        // R9 masked edge stays pending
        put(8'h20, 32'h0001_0066);
        @(negedge clk) irq_in[8] = 1'b1;
        @(negedge clk) irq_in[8] = 1'b0;
        expect_quiet("R9 masked line silent");
        put(8'h20, 32'h0000_0066);
        take_msg("R9 pending sent on unmask", 8'h66, 16'h0, 0);

        // R11 round robin
        put(8'h22, 32'h0000_0091);
        put(8'h24, 32'h0000_00A1);
        put(8'h26, 32'h0000_00B1);
        put(8'h28, 32'h0000_00C1);
        @(negedge clk) irq_in[11:9] = 3'b111;
        take_msg("R11 first after last served", 8'h91, 16'h0, 0);
        take_msg("R11 second", 8'hA1, 16'h0, 0);
        take_msg("R11 third", 8'hB1, 16'h0, 0);
        @(negedge clk) irq_in[11:9] = 3'b000;
        @(negedge clk) begin irq_in[10] = 1'b1; irq_in[12] = 1'b1; end
        take_msg("R11 wraps past last served", 8'hC1, 16'h0, 0);
        take_msg("R11 then lower index", 8'hA1, 16'h0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule